// File: doc/BRIEF.md
# Time-Multiplexed Constant Multiplier

The block multiplies a signed 8-bit sample by one constant chosen from a fixed set of three: 362, 392 and 473. It has no hardware multiplier. It uses a small shift-and-add network that serves all three constants. A phase index selects the constant.

The block runs on an internal clock that is several times faster than the sample rate. One product takes three control steps, and each step evaluates one level of adders:

- **Step one:** two adders each combine two shifted copies of the latched sample. A sign flag on each copy makes that operand a subtraction.
- **Step two:** one adder sums the two partial results.
- **Step three:** one adder applies a phase-dependent shift to that sum and adds an optional final term.

All three phases use the same adders. A per-phase term table drives the operand multiplexers at each step. For example, the step-one adder computes 512x-128x in phase 0, 64x-16x in phase 1 and 512x-32x in phase 2. The 392 product is formed as 49x shifted left by three at the last step.

A small state machine sequences the work. The states are:

- `S_IDLE`: waiting for work.
- `S_STEP1`: first adder level.
- `S_STEP2`: second adder level.
- `S_STEP3`: third adder level.

The transitions are:

- **accept:** `S_IDLE` to `S_STEP1` when start is high.
- **advance:** `S_STEP1` to `S_STEP2`, then `S_STEP2` to `S_STEP3`.
- **finish:** `S_STEP3` to `S_IDLE`.
- **wait:** `S_IDLE` stays in `S_IDLE` when start is low.

The sample and phase are latched on accept. The product is registered at the end of `S_STEP3`, and done pulses for one cycle.

Top module: `rcm_mult`

## Requirements
- R1: With phase code 0, the completed product equals the signed sample times 362.
- R2: With phase code 1, the completed product equals the signed sample times 392.
- R3: With phase code 2, the completed product equals the signed sample times 473.
- R4: Phase code 3 is not a valid selection, and its completed product is 0.
- R5: Suppose start is high at a clock edge while the block is idle. Then done is high for exactly one cycle, following the fourth edge counted from that one. Done is low in every other cycle.
- R6: The product output is a register. It changes only at the edge where done rises, and it holds its value until the next completion.
- R7: A start pulse while the block is busy is ignored. Changes to the sample or the phase after acceptance do not affect the result in progress.
- R8: A start given in the same cycle that done is high is accepted, so operations can follow each other with no idle gap.
- R9: After the active-low asynchronous reset, the block is idle with product 0 and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal control-step clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication (taken only when idle) |
| phase | input | 2 | Constant select: 0=362, 1=392, 2=473, 3=none |
| x_in | input | 8 | Signed input sample |
| product | output | 18 | Signed registered product |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the done pulse of one result and the acceptance of the next start. Back-to-back operations provoke this case by driving a fresh start in the very cycle done is high. The check is that the earlier product is intact in that cycle and that the new result appears exactly four edges later.

A second overlap is a start held high through the busy steps with a different sample and phase. The check is that the result still matches the operands latched at acceptance.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int SHIFT_W   = 4;
    localparam int NUM_TERMS = 5;   // four at step one, one at step three

    typedef struct packed {
        logic               en;
        logic               neg;
        logic [SHIFT_W-1:0] sh;
    } term_t;

    typedef struct packed {
        term_t [NUM_TERMS-1:0] t;       // t[0],t[1] adder A; t[2],t[3] adder B; t[4] final
        logic  [SHIFT_W-1:0]   post_sh; // shift applied to the step-two sum at step three
    } phase_cfg_t;

    function automatic term_t mk(input logic en, input logic neg, input int sh);
        term_t r;
        r.en  = en;
        r.neg = neg;
        r.sh  = SHIFT_W'(sh);
        return r;
    endfunction

    // Operand-mux contents per phase: 362, 392 (49<<3), 473, and an empty row
    function automatic phase_cfg_t phase_cfg(input logic [1:0] ph);
        phase_cfg_t c;
        c.post_sh = '0;
        for (int i = 0; i < NUM_TERMS; i++) c.t[i] = mk(1'b0, 1'b0, 0);
        unique case (ph)
            2'd0: begin
                c.t[0] = mk(1'b1, 1'b0, 9); c.t[1] = mk(1'b1, 1'b1, 7);
                c.t[2] = mk(1'b1, 1'b1, 5); c.t[3] = mk(1'b1, 1'b0, 3);
                c.t[4] = mk(1'b1, 1'b0, 1);
            end
            2'd1: begin
                c.t[0] = mk(1'b1, 1'b0, 6); c.t[1] = mk(1'b1, 1'b1, 4);
                c.t[2] = mk(1'b1, 1'b0, 0);
                c.post_sh = SHIFT_W'(3);
            end
            2'd2: begin
                c.t[0] = mk(1'b1, 1'b0, 9); c.t[1] = mk(1'b1, 1'b1, 5);
                c.t[2] = mk(1'b1, 1'b1, 3); c.t[3] = mk(1'b1, 1'b0, 0);
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rcm_term.sv
module rcm_term
    import rcm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PROD_W = 18
) (
    input  logic signed [DATA_W-1:0] x_i,
    input  term_t                    cfg_i,
    output logic signed [PROD_W-1:0] val_o
);
    localparam int EXT_W = PROD_W - DATA_W;

    logic signed [PROD_W-1:0] ext;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        ext     = {{EXT_W{x_i[DATA_W-1]}}, x_i};
        shifted = ext <<< cfg_i.sh;
        if (!cfg_i.en)
            val_o = '0;
        else if (cfg_i.neg)
            val_o = -shifted;
        else
            val_o = shifted;
    end
endmodule

// File: rtl/rcm_ctrl.sv
module rcm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step1_o,
    output logic step2_o,
    output logic step3_o,
    output logic done_o
);
    typedef enum logic [1:0] {S_IDLE, S_STEP1, S_STEP2, S_STEP3} state_t;

    state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_STEP1;   // accept
            S_STEP1: state_d = S_STEP2;                 // advance
            S_STEP2: state_d = S_STEP3;                 // advance
            S_STEP3: state_d = S_IDLE;                  // finish
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        step1_o = 1'b0;
        step2_o = 1'b0;
        step3_o = 1'b0;
        unique case (state_q)
            S_IDLE:  load_o  = start_i;
            S_STEP1: step1_o = 1'b1;
            S_STEP2: step2_o = 1'b1;
            S_STEP3: step3_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == S_STEP3);
    end

    // R5: the completion pulse never lasts two cycles
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a start seen while busy never restarts the sequence
    a_r7_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (state_q != S_STEP1));

    // R8: a start while idle always begins step one
    a_r8_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i) |=> (state_q == S_STEP1));
endmodule

// File: rtl/rcm_datapath.sv
module rcm_datapath
    import rcm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PROD_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     step1_i,
    input  logic                     step2_i,
    input  logic                     step3_i,
    input  logic [1:0]               phase_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic signed [PROD_W-1:0] prod_o
);
    logic signed [DATA_W-1:0] x_q;
    logic [1:0]               ph_q;
    logic signed [PROD_W-1:0] acc_a, acc_b;
    phase_cfg_t               cfg;
    logic signed [PROD_W-1:0] tv [NUM_TERMS];
    logic signed [PROD_W-1:0] final_sum;

    always_comb cfg = phase_cfg(ph_q);

    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
        rcm_term #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_term (
            .x_i   (x_q),
            .cfg_i (cfg.t[g]),
            .val_o (tv[g])
        );
    end

    always_comb final_sum = (acc_a <<< cfg.post_sh) + tv[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            ph_q   <= '0;
            acc_a  <= '0;
            acc_b  <= '0;
            prod_o <= '0;
        end else begin
            if (load_i) begin
                x_q  <= x_i;
                ph_q <= phase_i;
            end
            if (step1_i) begin
                acc_a <= tv[0] + tv[1];
                acc_b <= tv[2] + tv[3];
            end
            if (step2_i) acc_a <= acc_a + acc_b;
            if (step3_i) prod_o <= final_sum;
        end
    end
endmodule

// File: rtl/rcm_mult.sv
module rcm_mult #(
    parameter int DATA_W = 8,
    parameter int PROD_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               phase,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [PROD_W-1:0] product,
    output logic                     done
);
    logic load, step1, step2, step3;

    rcm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .load_o  (load),
        .step1_o (step1),
        .step2_o (step2),
        .step3_o (step3),
        .done_o  (done)
    );

    rcm_datapath #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step1_i (step1),
        .step2_i (step2),
        .step3_i (step3),
        .phase_i (phase),
        .x_i     (x_in),
        .prod_o  (product)
    );

    // R6: the product register moves only together with the done pulse
    a_r6_product_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product) |-> done);
endmodule

// File: tb/rcm_mult_tb.sv
module rcm_mult_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        phase = '0;
    logic signed [7:0] x_in = '0;
    logic signed [17:0] product;
    logic              done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rcm_mult u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
        .x_in(x_in), .product(product), .done(done)
    );

    function automatic logic signed [17:0] exp_prod(input logic signed [7:0] xv,
                                                    input logic [1:0] pv);
        int c;
        case (pv)
            2'd0:    c = 362;
            2'd1:    c = 392;
            2'd2:    c = 473;
            default: c = 0;
        endcase
        return 18'(int'(xv) * c);
    endfunction

    function automatic string req_of(input logic [1:0] pv);
        case (pv)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Called just after a falling edge with the block idle or finishing.
    // Ends at the falling edge where done should be high.
    task automatic op(input logic signed [7:0] xv, input logic [1:0] pv, input bit poke);
        logic signed [17:0] e;
        e = exp_prod(xv, pv);
        start = 1'b1; x_in = xv; phase = pv;
        @(negedge clk);                        // accepted
        if (poke) begin                        // R7: busy start with other operands
            start = 1'b1; x_in = ~xv; phase = pv + 2'd1;
        end else begin
            start = 1'b0; x_in = $urandom; phase = 2'($urandom);
        end
        @(negedge clk);
        check("R5", done, 0);
        @(negedge clk);
        check("R5", done, 0);
        start = 1'b0;
        @(negedge clk);
        check("R5", done, 1);
        check(poke ? "R7" : req_of(pv), product, e);
    endtask

    task automatic idle_after(input logic signed [17:0] held);
        start = 1'b0;
        @(negedge clk);
        check("R5", done, 0);
        check("R6", product, held);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9", product, 0);
        check("R9", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", done, 0);

        // Corner operands on every phase, including the invalid code
        for (int p = 0; p < 4; p++) begin
            op(8'sh7f, 2'(p), 1'b0); idle_after(exp_prod(8'sh7f, 2'(p)));
            op(-8'sd128, 2'(p), 1'b0); idle_after(exp_prod(-8'sd128, 2'(p)));
            op(8'sd0, 2'(p), 1'b0); idle_after(18'sd0);
        end

        // Exhaustive sweep of the valid phases, run back-to-back (R8)
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 256; v++) begin
                op(8'(v), 2'(p), 1'b0);
            end
            idle_after(exp_prod(8'sd255, 2'(p)));
        end

        // R8: a start in the done cycle keeps the old product, then the new one follows
        op(8'sd100, 2'd2, 1'b0);
        check("R8", product, exp_prod(8'sd100, 2'd2));
        op(-8'sd77, 2'd0, 1'b0);
        check("R8", product, exp_prod(-8'sd77, 2'd0));
        idle_after(exp_prod(-8'sd77, 2'd0));

        // R7: start held through busy steps with different operands
        for (int k = 0; k < 40; k++) begin
            logic signed [7:0] xv;
            logic [1:0] pv;
            xv = 8'($urandom);
            pv = 2'($urandom_range(0, 3));
            op(xv, pv, 1'b1);
            idle_after(exp_prod(xv, pv));
        end

        // Constrained random mix, with idle gaps of random length
        for (int k = 0; k < 300; k++) begin
            logic signed [7:0] xv;
            logic [1:0] pv;
            xv = 8'($urandom);
            pv = 2'($urandom_range(0, 3));
            op(xv, pv, 1'b0);
            if ($urandom_range(0, 1) == 1) begin
                int gap;
                gap = $urandom_range(1, 4);
                for (int g = 0; g < gap; g++) idle_after(exp_prod(xv, pv));
            end
        end

        // R9: reset in mid-flight clears the product and done
        start = 1'b1; x_in = 8'sd9; phase = 2'd0;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R9", product, 0);
        check("R9", done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", done, 0);
        check("R9", product, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule